// File: doc/BRIEF.md
# CAN Transceiver Mode Controller

This block is the digital control core of a high-speed CAN transceiver. It takes the controller's transmit line, an enable pin, an active-low functional reset request and the digitised output of the bus comparator. It produces the driver command, the bus-bias selection and the receive line that goes back to the controller. The analog front end, the bias voltages and the comparator thresholds sit outside it.

In normal mode the driver follows transmit data, but a dominant level that lasts too long is cut off, and the driver stays recessive until transmit data returns high. When the block is disabled or held in reset, it enters wake-detect mode. The driver is silenced, the bus is biased to ground, and the receive line is held high until a dominant–recessive–dominant wake pattern has been recognised. Every time limit is a parameter counted in clock cycles, and the transmit and bus inputs each pass through a two-flop synchroniser.

Top module: `can_xcvr_ctrl`

## Requirements
- R1: In normal mode, a continuous low on `txData` gives at most `DOM_TIMEOUT` clock cycles of `drvDominant` high. After that the driver returns to recessive (0) on its own.
- R2: After a dominant timeout, `drvDominant` stays 0 while `txData` stays low. Once `txData` has been high for at least one synchronised cycle, a new low drives dominant again, and each high on `txData` restarts the dominant time budget.
- R3: When `canEnable` is 0 or `resetReqN` is 0 (wake-detect mode), `drvDominant` is 0 whatever `txData` is, and `biasHalf` is 0 (ground bias). The dominant timer is held cleared in this mode, so a later enable starts with a full budget.
- R4: When `canEnable` is 1 and `resetReqN` is 1 (normal mode), `biasHalf` is 1, `drvDominant` is the inverse of `txData`, and `rxData` is the inverse of `busDominant` (1 means the bus is dominant). Each of these follows its input two clock cycles later, through the synchronisers.
- R5: In wake-detect mode, `rxData` stays 1 until three phases have been seen in order: dominant, then recessive, then dominant, each lasting at least `WAKE_FILT` cycles.
- R6: After a wake pattern is recognised in wake-detect mode, `rxData` follows the inverse of `busDominant`. Entering normal mode clears the recognition, so the next wake-detect period needs a fresh pattern.
- R7: The wake pattern must complete within `WAKE_TO` cycles of the start of its first dominant phase. Otherwise the detector returns to searching, and `rxData` stays 1.
- R8: A bus phase shorter than `WAKE_FILT` cycles is a glitch. It restarts the qualification of the current phase and does not advance the pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low power-on reset of the block's flops |
| txData | input | 1 | Transmit data from the controller, 0 = dominant |
| canEnable | input | 1 | Transceiver enable, 1 = normal operation requested |
| resetReqN | input | 1 | Active-low functional reset (from supply or watchdog supervision); 0 forces wake-detect mode |
| busDominant | input | 1 | Comparator output, 1 = differential bus voltage is dominant |
| drvDominant | output | 1 | Command to the bus driver, 1 = drive dominant |
| biasHalf | output | 1 | Bias select, 1 = half-supply bias, 0 = ground bias |
| rxData | output | 1 | Receive data to the controller, 0 = dominant |

## Verification
The bench holds transmit low far past the limit and measures exactly how many cycles the driver stays on. A design that never timed out, or that released the lockout while transmit was still low, would give the wrong count or re-drive dominant. It drops transmit into low again after a short high, and after a long low held in wake-detect mode. These catch a timer that is not restarted or not held cleared; such a timer would cut the next dominant short. The wake tests cover a clean pattern, a pattern with a too-short recessive phase, and a pattern whose recessive phase runs past the deadline. A detector that advanced on a glitch, had no deadline, or kept its recognition across a normal-mode visit would release the receive line when it must stay high.

// File: rtl/can_ctrl_pkg.sv
package can_ctrl_pkg;

  // Strobes from the control module to the counter datapath
  typedef struct packed {
    logic domRun;       // transmitter is asking for dominant in normal mode
    logic phaseClr;     // wake phase counter held at zero
    logic expectRec;    // current wake phase expects a recessive bus
    logic deadlineRun;  // wake pattern deadline counter running
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    WK_IDLE = 3'd0,
    WK_DOM1 = 3'd1,
    WK_REC  = 3'd2,
    WK_DOM2 = 3'd3,
    WK_DONE = 3'd4
  } wakeState_t;

endpackage

// File: rtl/can_ctrl_sync.sv
module can_ctrl_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= RESET_VAL;
          else       chain[s] <= dIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= RESET_VAL;
          else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/can_ctrl_datapath.sv
module can_ctrl_datapath
  import can_ctrl_pkg::*;
#(
  parameter int DOM_TIMEOUT = 40,
  parameter int WAKE_FILT   = 5,
  parameter int WAKE_TO     = 60
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  input  logic        busS,
  output logic        domExpired,
  output logic        phaseOk,
  output logic        deadlineHit
);
  localparam int DOM_W   = $clog2(DOM_TIMEOUT + 1);
  localparam int PHASE_W = $clog2(WAKE_FILT + 1);
  localparam int DL_W    = $clog2(WAKE_TO + 1);
  localparam logic [DOM_W-1:0]   DOM_LAST = DOM_W'(DOM_TIMEOUT - 1);
  localparam logic [PHASE_W-1:0] PH_LAST  = PHASE_W'(WAKE_FILT);
  localparam logic [DL_W-1:0]    DL_LAST  = DL_W'(WAKE_TO - 1);

  logic [DOM_W-1:0]   domCnt;
  logic [PHASE_W-1:0] phaseCnt;
  logic [DL_W-1:0]    deadlineCnt;
  logic               atLevel;

  assign atLevel     = busS ^ ctl.expectRec;
  assign domExpired  = (domCnt == DOM_LAST);
  assign phaseOk     = (phaseCnt == PH_LAST);
  assign deadlineHit = (deadlineCnt == DL_LAST);

  // Dominant length counter, cleared whenever transmit is recessive or in wake mode
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)               domCnt <= '0;
    else if (!ctl.domRun)    domCnt <= '0;
    else if (!domExpired)    domCnt <= domCnt + 1'b1;

  // Wake phase length counter, cleared when the bus leaves the expected level
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                          phaseCnt <= '0;
    else if (ctl.phaseClr || !atLevel)  phaseCnt <= '0;
    else if (!phaseOk)                  phaseCnt <= phaseCnt + 1'b1;

  // Overall wake pattern deadline
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                  deadlineCnt <= '0;
    else if (!ctl.deadlineRun)  deadlineCnt <= '0;
    else if (!deadlineHit)      deadlineCnt <= deadlineCnt + 1'b1;

  // A qualified phase needs the bus to have sat at its level on the last edge
  assert_phase_qual_R8: assert property (@(posedge clk) disable iff (!rstN)
    phaseOk |-> $past(atLevel && !ctl.phaseClr));

endmodule

// File: rtl/can_ctrl_control.sv
module can_ctrl_control
  import can_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txS,
  input  logic        busS,
  input  logic        canEnable,
  input  logic        resetReqN,
  input  logic        domExpired,
  input  logic        phaseOk,
  input  logic        deadlineHit,
  output ctlStrobes_t ctl,
  output logic        drvDominant,
  output logic        biasHalf,
  output logic        rxData,
  output logic        wakeSeen
);
  wakeState_t state, stateNext;
  logic normalMode, domRun, lockout, inPattern;

  assign normalMode = canEnable & resetReqN;
  assign domRun     = normalMode & ~txS;
  assign inPattern  = (state == WK_DOM1) || (state == WK_REC) || (state == WK_DOM2);
  assign wakeSeen   = (state == WK_DONE);

  // Lockout after an over-long dominant; released only by recessive transmit
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           lockout <= 1'b0;
    else if (!domRun)    lockout <= 1'b0;
    else if (domExpired) lockout <= 1'b1;

  always_comb begin
    stateNext = state;
    if (normalMode) stateNext = WK_IDLE;
    else begin
      case (state)
        WK_IDLE: if (busS) stateNext = WK_DOM1;
        WK_DOM1: if (deadlineHit) stateNext = WK_IDLE;
                 else if (!busS) stateNext = phaseOk ? WK_REC : WK_IDLE;
        WK_REC:  if (deadlineHit) stateNext = WK_IDLE;
                 else if (busS && phaseOk) stateNext = WK_DOM2;
        WK_DOM2: if (deadlineHit) stateNext = WK_IDLE;
                 else if (phaseOk) stateNext = WK_DONE;
        WK_DONE: stateNext = WK_DONE;
        default: stateNext = WK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= WK_IDLE;
    else       state <= stateNext;

  always_comb begin
    ctl.domRun      = domRun;
    ctl.phaseClr    = !inPattern;
    ctl.expectRec   = (state == WK_REC);
    ctl.deadlineRun = inPattern;
  end

  assign drvDominant = domRun & ~lockout;
  assign biasHalf    = normalMode;
  assign rxData      = (normalMode || wakeSeen) ? ~busS : 1'b1;

  assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lockout && domRun) |=> (lockout || !domRun));

  assert_wake_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wakeSeen && !$past(wakeSeen)) |-> ($past(state) == WK_DOM2));

  assert_deadline_R7: assert property (@(posedge clk) disable iff (!rstN)
    (deadlineHit && inPattern && !normalMode) |=> (state == WK_IDLE));

endmodule

// File: rtl/can_xcvr_ctrl.sv
module can_xcvr_ctrl
  import can_ctrl_pkg::*;
#(
  parameter int DOM_TIMEOUT = 40,
  parameter int WAKE_FILT   = 5,
  parameter int WAKE_TO     = 60,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic txData,
  input  logic canEnable,
  input  logic resetReqN,
  input  logic busDominant,
  output logic drvDominant,
  output logic biasHalf,
  output logic rxData
);
  logic txS, busS, domExpired, phaseOk, deadlineHit, wakeSeen;
  ctlStrobes_t ctlBus;

  can_ctrl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_txSync (
    .clk(clk), .rstN(rstN), .dIn(txData), .dOut(txS));

  can_ctrl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_busSync (
    .clk(clk), .rstN(rstN), .dIn(busDominant), .dOut(busS));

  can_ctrl_datapath #(
    .DOM_TIMEOUT(DOM_TIMEOUT), .WAKE_FILT(WAKE_FILT), .WAKE_TO(WAKE_TO)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .busS(busS),
    .domExpired(domExpired), .phaseOk(phaseOk), .deadlineHit(deadlineHit));

  can_ctrl_control u_control (
    .clk(clk), .rstN(rstN), .txS(txS), .busS(busS),
    .canEnable(canEnable), .resetReqN(resetReqN),
    .domExpired(domExpired), .phaseOk(phaseOk), .deadlineHit(deadlineHit),
    .ctl(ctlBus), .drvDominant(drvDominant), .biasHalf(biasHalf),
    .rxData(rxData), .wakeSeen(wakeSeen));

  assert_dom_limit_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctlBus.domRun && domExpired) |=> !drvDominant);

  assert_wake_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(canEnable && resetReqN) |-> (!biasHalf && !drvDominant));

  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!(canEnable && resetReqN) && !wakeSeen) |-> rxData);

endmodule

// File: tb/can_xcvr_ctrl_tb.sv
`timescale 1ns/1ps
module can_xcvr_ctrl_tb;
  localparam int DOM_TIMEOUT = 40;
  localparam int WAKE_FILT   = 5;
  localparam int WAKE_TO     = 60;

  logic clk = 1'b0;
  logic rstN, txData, canEnable, resetReqN, busDominant;
  logic drvDominant, biasHalf, rxData;
  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  can_xcvr_ctrl #(.DOM_TIMEOUT(DOM_TIMEOUT), .WAKE_FILT(WAKE_FILT), .WAKE_TO(WAKE_TO)) u_dut (
    .clk(clk), .rstN(rstN), .txData(txData), .canEnable(canEnable),
    .resetReqN(resetReqN), .busDominant(busDominant),
    .drvDominant(drvDominant), .biasHalf(biasHalf), .rxData(rxData));

  // {canEnable, resetReqN, txData, busDominant, expDrv, expBias, expRx}
  localparam logic [6:0] VEC [8] = '{
    7'b1110_011, 7'b1100_111, 7'b1111_010, 7'b1101_110,
    7'b0101_001, 7'b1001_001, 7'b0000_001, 7'b0111_001};

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic act, logic exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic toNormal();
    canEnable = 1'b1; busDominant = 1'b0; txData = 1'b1;
    step(4);
    canEnable = 1'b0;
    step(4);
  endtask

  task automatic busPhase(logic lvl, int n);
    busDominant = lvl;
    step(n);
  endtask

  initial begin
    #1000000;
    failCnt++;
    $display("FAIL all requirements (watchdog): actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    int onCycles;
    rstN = 1'b0; txData = 1'b1; canEnable = 1'b0; resetReqN = 1'b1; busDominant = 1'b0;
    step(3);
    check("R3 reset drv", drvDominant, 1'b0);
    check("R3 reset bias", biasHalf, 1'b0);
    check("R5 reset rx", rxData, 1'b1);
    rstN = 1'b1;
    step(2);

    // Steady-state mode table (R3, R4)
    for (int i = 0; i < 8; i++) begin
      {canEnable, resetReqN, txData, busDominant} = VEC[i][6:3];
      step(4);
      check($sformatf("R4/R3 vec%0d drv", i), drvDominant, VEC[i][2]);
      check($sformatf("R4/R3 vec%0d bias", i), biasHalf, VEC[i][1]);
      check($sformatf("R4/R3 vec%0d rx", i), rxData, VEC[i][0]);
      txData = 1'b1; busDominant = 1'b0;
      step(3);
    end

    // R1: dominant limited to exactly DOM_TIMEOUT cycles
    canEnable = 1'b1; resetReqN = 1'b1; txData = 1'b1; busDominant = 1'b0;
    step(4);
    txData = 1'b0;
    onCycles = 0;
    for (int i = 0; i < 100; i++) begin
      step(1);
      if (drvDominant) onCycles++;
    end
    check("R1 dominant length", onCycles == DOM_TIMEOUT, 1'b1);
    if (onCycles != DOM_TIMEOUT)
      $display("  R1 detail: actual=%0d expected=%0d", onCycles, DOM_TIMEOUT);
    // R2: still locked, then released by a recessive
    check("R2 locked while low", drvDominant, 1'b0);
    txData = 1'b1; step(3);
    txData = 1'b0; step(3);
    check("R2 release after recessive", drvDominant, 1'b1);
    // R2: restart of budget at each high
    step(27);
    txData = 1'b1; step(3);
    txData = 1'b0; step(30);
    check("R2 budget restarted", drvDominant, 1'b1);
    txData = 1'b1; step(3);

    // R3: timer held cleared in wake mode
    canEnable = 1'b0; txData = 1'b0;
    step(60);
    check("R3 tx ignored in wake mode", drvDominant, 1'b0);
    canEnable = 1'b1;
    step(1);
    check("R3 full budget after enable", drvDominant, 1'b1);
    txData = 1'b1; step(3);

    // R5/R6: clean wake pattern
    toNormal();
    busPhase(1'b1, 10); busPhase(1'b0, 10);
    check("R5 rx high mid-pattern", rxData, 1'b1);
    busPhase(1'b1, 10);
    check("R6 rx follows dominant after wake", rxData, 1'b0);
    busPhase(1'b0, 4);
    check("R6 rx follows recessive after wake", rxData, 1'b1);
    busPhase(1'b1, 4);
    check("R6 rx follows dominant again", rxData, 1'b0);
    // R6: normal-mode visit clears recognition
    toNormal();
    busPhase(1'b1, 4);
    check("R6 recognition cleared", rxData, 1'b1);
    busPhase(1'b0, 10);

    // R8: short recessive is a glitch, then a proper recessive completes it
    toNormal();
    busPhase(1'b1, 10); busPhase(1'b0, 3); busPhase(1'b1, 10);
    check("R8 glitch does not advance", rxData, 1'b1);
    busPhase(1'b0, 10); busPhase(1'b1, 10);
    check("R8 pattern completes after requalify", rxData, 1'b0);

    // R7: recessive phase overruns the deadline
    toNormal();
    busPhase(1'b1, 10); busPhase(1'b0, 70); busPhase(1'b1, 10);
    check("R7 deadline resets detector", rxData, 1'b1);
    busPhase(1'b0, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule